// File: doc/BRIEF.md
# Cluster Node Timestamp Receiver

Each node in a cluster carries one copy of this block. A shared timing line feeds it three single-cycle strobes, already recovered into the local clock domain: a fine tick, a valid flag for each bit of a slow serial data stream, and an epoch pulse. Each tick advances a sub-second counter. The serial stream carries the absolute epoch value in seconds and fills a shift register one bit at a time. When the epoch pulse arrives, the block copies that value into an epoch register and restarts the sub-second count from zero.

A read request captures a timestamp in one cycle. The timestamp holds the epoch in its upper bits, the sub-second count in the middle bits and a static node identifier in its lowest bits. Because every node has a different identifier, two nodes that read in the same instant still produce different timestamps. Comparing two timestamps as plain unsigned numbers orders them by time first. When the times are equal, the node with the smaller identifier comes first.

Top module: `ts_node_rx`

## Requirements
- R1: After reset, `synced_o` is 0, `rd_vld_o` is 0, and a read returns epoch 0, sub-second count 0 and the node ID.
- R2: Each `tick_i` strobe without an epoch pulse raises the sub-second count by exactly one. No tick means no change.
- R3: Serial bits enter most significant bit first, one per `bit_vld_i` strobe. After EPOCH_W strobes, an epoch pulse makes the epoch field equal to the word sent.
- R4: An epoch pulse sets the sub-second count to zero in the same cycle. A tick in the same cycle as an epoch pulse is ignored.
- R5: The sub-second count saturates at 2^SUB_W-1 and does not wrap while no epoch pulse arrives.
- R6: The lowest NODE_W bits of every timestamp equal the NODE_ID parameter.
- R7: `rd_vld_o` is high for exactly the one cycle after a cycle with `rd_req_i` high. In that cycle `rd_ts_o` holds the epoch and count as they were before the request edge, so a tick in the request cycle is not included.
- R8: `synced_o` goes high in the cycle after the first epoch pulse and stays high until reset.
- R9: When two nodes read in the same cycle, the timestamp of the node with the lower node ID is the smaller unsigned value. A timestamp taken at a later time is larger than one taken earlier, whatever the node IDs.
- R10: The epoch field changes only on an epoch pulse. Serial bits that shift in between pulses do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Fine time tick strobe |
| bit_vld_i | input | 1 | Strobe marking a valid serial epoch bit |
| bit_i | input | 1 | Serial epoch data bit |
| epoch_i | input | 1 | Epoch pulse: load the epoch, restart the count |
| rd_req_i | input | 1 | Timestamp read request |
| rd_vld_o | output | 1 | Timestamp valid, one cycle after the request |
| rd_ts_o | output | EPOCH_W+SUB_W+NODE_W | Timestamp {epoch, sub-second count, node ID} |
| synced_o | output | 1 | High once an epoch pulse has been received |

## Verification
The assertions assume that every strobe lasts one cycle, is already synchronous to `clk_i`, and may occur in any combination with the other strobes. They also assume that the serial stream has finished a full word before the epoch pulse that should load it. The bench changes inputs only on the falling edge and holds each strobe for exactly one cycle. It always sends complete EPOCH_W-bit words before an epoch pulse. It also puts strobes in the same cycle on purpose (tick with epoch, tick with read) to exercise the priority rules.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned DEF_EPOCH_W = 32;
  localparam int unsigned DEF_SUB_W   = 24;
  localparam int unsigned DEF_NODE_W  = 16;

  function automatic int unsigned ts_width(int unsigned ew, int unsigned sw, int unsigned nw);
    return ew + sw + nw;
  endfunction
endpackage

// File: rtl/ts_epoch_shreg.sv
module ts_epoch_shreg #(
  parameter int unsigned W = ts_pkg::DEF_EPOCH_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  output logic [W-1:0] shreg_o
);
  logic [W-1:0] sh_q;

  // first bit received ends up in the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '0;
    else if (bit_vld_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign shreg_o = sh_q;
endmodule

// File: rtl/ts_fine_cnt.sv
module ts_fine_cnt #(
  parameter int unsigned W = ts_pkg::DEF_SUB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CntMax = '1;

  logic [W-1:0] cnt_q;
  logic         at_max;

  assign at_max = (cnt_q == CntMax);

  // clear beats tick; saturate instead of wrapping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (tick_i && !at_max) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ts_epoch_latch.sv
module ts_epoch_latch #(
  parameter int unsigned W = ts_pkg::DEF_EPOCH_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         synced_o
);
  logic [W-1:0] ep_q;
  logic         sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ep_q   <= '0;
      sync_q <= 1'b0;
    end else if (load_i) begin
      ep_q   <= d_i;
      sync_q <= 1'b1;
    end
  end

  assign q_o      = ep_q;
  assign synced_o = sync_q;
endmodule

// File: rtl/ts_read_port.sv
module ts_read_port #(
  parameter int unsigned W = ts_pkg::ts_width(ts_pkg::DEF_EPOCH_W, ts_pkg::DEF_SUB_W,
                                              ts_pkg::DEF_NODE_W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] ts_o
);
  logic         vld_q;
  logic [W-1:0] ts_q;

  // one register stage: every field is taken at the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) ts_q <= d_i;
    end
  end

  assign vld_o = vld_q;
  assign ts_o  = ts_q;
endmodule

// File: rtl/ts_node_rx.sv
module ts_node_rx #(
  parameter int unsigned     EPOCH_W = ts_pkg::DEF_EPOCH_W,
  parameter int unsigned     SUB_W   = ts_pkg::DEF_SUB_W,
  parameter int unsigned     NODE_W  = ts_pkg::DEF_NODE_W,
  parameter logic [NODE_W-1:0] NODE_ID = '0,
  localparam int unsigned    TS_W    = ts_pkg::ts_width(EPOCH_W, SUB_W, NODE_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            bit_vld_i,
  input  logic            bit_i,
  input  logic            epoch_i,
  input  logic            rd_req_i,
  output logic            rd_vld_o,
  output logic [TS_W-1:0] rd_ts_o,
  output logic            synced_o
);
  logic [EPOCH_W-1:0] shreg;
  logic [EPOCH_W-1:0] epoch_q;
  logic [SUB_W-1:0]   sub_q;
  logic [TS_W-1:0]    ts_now;

  ts_epoch_shreg #(.W(EPOCH_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .shreg_o   (shreg)
  );

  ts_fine_cnt #(.W(SUB_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (epoch_i),
    .cnt_o  (sub_q)
  );

  ts_epoch_latch #(.W(EPOCH_W)) u_epoch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (epoch_i),
    .d_i      (shreg),
    .q_o      (epoch_q),
    .synced_o (synced_o)
  );

  // node ID in the low bits breaks ties between nodes
  assign ts_now = {epoch_q, sub_q, NODE_ID};

  ts_read_port #(.W(TS_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rd_req_i),
    .d_i    (ts_now),
    .vld_o  (rd_vld_o),
    .ts_o   (rd_ts_o)
  );
endmodule

// File: rtl/ts_node_rx_chk.sv
module ts_node_rx_chk #(
  parameter int unsigned EPOCH_W = 32,
  parameter int unsigned SUB_W   = 24
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               epoch_i,
  input logic               rd_req_i,
  input logic               rd_vld_o,
  input logic               synced_o,
  input logic [EPOCH_W-1:0] shreg,
  input logic [EPOCH_W-1:0] epoch_q,
  input logic [SUB_W-1:0]   sub_q
);
  localparam logic [SUB_W-1:0] SubMax = '1;

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !epoch_i && sub_q != SubMax) |=> (sub_q == $past(sub_q) + SUB_W'(1))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !epoch_i) |=> $stable(sub_q)); // R2
  AST_EPOCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_i |=> (epoch_q == $past(shreg))); // R3
  AST_EPOCH_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_i |=> (sub_q == '0)); // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_q == SubMax && !epoch_i) |=> (sub_q == SubMax)); // R5
  AST_RD_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_vld_o); // R7
  AST_RD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_vld_o); // R7
  AST_SYNC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_i |=> synced_o); // R8
  AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced_o |=> synced_o); // R8
  AST_EPOCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !epoch_i |=> $stable(epoch_q)); // R10
endmodule

bind ts_node_rx ts_node_rx_chk #(.EPOCH_W(EPOCH_W), .SUB_W(SUB_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .epoch_i  (epoch_i),
  .rd_req_i (rd_req_i),
  .rd_vld_o (rd_vld_o),
  .synced_o (synced_o),
  .shreg    (shreg),
  .epoch_q  (epoch_q),
  .sub_q    (sub_q)
);

// File: tb/ts_node_rx_test.sv
module ts_node_rx_test;
  localparam int unsigned EW = 32;
  localparam int unsigned SW = 6;
  localparam int unsigned NW = 16;
  localparam int unsigned TW = EW + SW + NW;
  localparam logic [NW-1:0] ID_A = 16'h00A5;
  localparam logic [NW-1:0] ID_B = 16'h0003;
  localparam logic [SW-1:0] SMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, bvld = 1'b0, bdat = 1'b0, ep = 1'b0, req = 1'b0;
  logic vld_a, vld_b, sync_a, sync_b;
  logic [TW-1:0] ts_a, ts_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ts_node_rx #(.EPOCH_W(EW), .SUB_W(SW), .NODE_W(NW), .NODE_ID(ID_A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bit_vld_i(bvld), .bit_i(bdat),
    .epoch_i(ep), .rd_req_i(req), .rd_vld_o(vld_a), .rd_ts_o(ts_a), .synced_o(sync_a));

  ts_node_rx #(.EPOCH_W(EW), .SUB_W(SW), .NODE_W(NW), .NODE_ID(ID_B)) uut_peer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bit_vld_i(bvld), .bit_i(bdat),
    .epoch_i(ep), .rd_req_i(req), .rd_vld_o(vld_b), .rd_ts_o(ts_b), .synced_o(sync_b));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk(input logic [EW-1:0] e, input logic [SW-1:0] s,
                                       input logic [NW-1:0] id);
    return {e, s, id};
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic send_word(input logic [EW-1:0] w);
    for (int i = EW - 1; i >= 0; i--) begin
      @(negedge clk) begin bvld = 1'b1; bdat = w[i]; end
    end
    @(negedge clk) begin bvld = 1'b0; bdat = 1'b0; end
  endtask

  task automatic pulse_epoch(input logic with_tick);
    @(negedge clk) begin ep = 1'b1; tick = with_tick; end
    @(negedge clk) begin ep = 1'b0; tick = 1'b0; end
  endtask

  // request at one negedge, result valid at the next
  task automatic do_read(input logic with_tick);
    @(negedge clk) begin req = 1'b1; tick = with_tick; end
    @(negedge clk) begin req = 1'b0; tick = 1'b0; end
    check("R7 vld", 64'(vld_a), 64'd1);
  endtask

  task automatic t_reset;
    check("R1 synced", 64'(sync_a), 64'd0);
    check("R1 vld", 64'(vld_a), 64'd0);
    do_read(1'b0);
    check("R1 ts", 64'(ts_a), 64'(mk('0, '0, ID_A)));
    check("R6 id", 64'(ts_a[NW-1:0]), 64'(ID_A));
  endtask

  task automatic t_ticks;
    ticks(5);
    do_read(1'b0);
    check("R2 five ticks", 64'(ts_a), 64'(mk('0, 6'd5, ID_A)));
    repeat (4) @(negedge clk);
    do_read(1'b0);
    check("R2 idle hold", 64'(ts_a), 64'(mk('0, 6'd5, ID_A)));
  endtask

  task automatic t_epoch_load;
    send_word(32'hDEAD_BEEF);
    do_read(1'b0);
    check("R10 no load before pulse", 64'(ts_a), 64'(mk('0, 6'd5, ID_A)));
    check("R8 not synced yet", 64'(sync_a), 64'd0);
    pulse_epoch(1'b0);
    check("R8 synced", 64'(sync_a), 64'd1);
    do_read(1'b0);
    check("R3 R4 loaded", 64'(ts_a), 64'(mk(32'hDEAD_BEEF, '0, ID_A)));
  endtask

  task automatic t_msb_first;
    send_word(32'h0000_0001);
    ticks(2);
    do_read(1'b0);
    check("R10 hold during shift", 64'(ts_a), 64'(mk(32'hDEAD_BEEF, 6'd2, ID_A)));
    pulse_epoch(1'b0);
    do_read(1'b0);
    check("R3 msb first", 64'(ts_a), 64'(mk(32'h0000_0001, '0, ID_A)));
  endtask

  task automatic t_tick_vs_epoch;
    ticks(3);
    pulse_epoch(1'b1);
    do_read(1'b0);
    check("R4 epoch beats tick", 64'(ts_a), 64'(mk(32'h0000_0001, '0, ID_A)));
    check("R8 stays synced", 64'(sync_a), 64'd1);
  endtask

  task automatic t_saturate;
    ticks(int'(SMAX) + 7);
    do_read(1'b0);
    check("R5 saturate", 64'(ts_a), 64'(mk(32'h0000_0001, SMAX, ID_A)));
    pulse_epoch(1'b0);
    ticks(1);
    do_read(1'b0);
    check("R5 restart after epoch", 64'(ts_a), 64'(mk(32'h0000_0001, 6'd1, ID_A)));
  endtask

  task automatic t_read_tick;
    do_read(1'b1);
    check("R7 tick in request cycle excluded", 64'(ts_a), 64'(mk(32'h0000_0001, 6'd1, ID_A)));
    @(negedge clk);
    check("R7 vld one cycle", 64'(vld_a), 64'd0);
    do_read(1'b0);
    check("R7 tick counted later", 64'(ts_a), 64'(mk(32'h0000_0001, 6'd2, ID_A)));
  endtask

  task automatic t_order;
    logic [TW-1:0] early_a;
    do_read(1'b0);
    check("R9 peer vld", 64'(vld_b), 64'd1);
    check("R9 lower id first", 64'(ts_b < ts_a), 64'd1);
    check("R6 peer id", 64'(ts_b[NW-1:0]), 64'(ID_B));
    early_a = ts_a;
    ticks(1);
    do_read(1'b0);
    check("R9 later time larger", 64'(ts_b > early_a), 64'd1);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ticks();
    t_epoch_load();
    t_msb_first();
    t_tick_vs_epoch();
    t_saturate();
    t_read_tick();
    t_order();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule